// File: doc/BRIEF.md
# Gated-Clock Serial Byte Transmitter

This block takes bytes written by a host and shifts them out on a single serial data output. Timing comes from an external transmit clock that may stop for long stretches (a burst or gated clock). That clock is brought into the fast system clock domain through a two-flop synchronizer, and its rising and falling edges are detected there. A small FIFO sits between the host write port and the shift register. A one-cycle transmitter reset strobe flushes the block and returns it to alignment.

After any reset, the transmitter must first see a falling edge of the transmit clock. Only then does it drive the first bit, on the next rising edge. This extra edge means a receiver that must capture on the very first clock edge cannot share the same gated clock.

Each bit stays on the output until the next rising edge, no matter how long the clock pauses. Bytes follow one another without gap bits. When the FIFO runs dry, the line idles high, and the next byte starts on a later rising edge without a new alignment.

Top module: `burst_ser_tx`

## Requirements
- R1: After reset, ser_o is 1, empty_o is 1, full_o is 0 and busy_o is 0. Whenever busy_o is 0, ser_o is 1.
- R2: After rst_ni or a txrst_i strobe, rising edges of tx_clk_i launch nothing until a falling edge has been seen. The first bit is then driven on the next rising edge.
- R3: A byte is sent least-significant bit first, with bit 0 through bit 7 on eight consecutive rising edges of tx_clk_i.
- R4: ser_o changes only as a result of a detected rising edge of tx_clk_i or of a reset. It holds through falling edges and through clock pauses of any length.
- R5: When the FIFO holds a byte as bit 7 finishes, bit 0 of that byte is driven on the very next rising edge, with no idle bit in between.
- R6: When the FIFO is empty as a byte finishes, the next rising edge drives ser_o to 1. A later write starts its byte on a following rising edge, without waiting for a falling edge first.
- R7: The FIFO holds 4 bytes. full_o is 1 while 4 are held, and a write (wr_i with wdata_i) made while full_o is 1 is dropped.
- R8: A one-cycle txrst_i pulse empties the FIFO, abandons any byte in progress and sets ser_o to 1 in the cycle that follows.
- R9: busy_o is 1 while the FIFO holds a byte or a byte is being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than tx_clk_i |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_clk_i | input | 1 | External, possibly gated, transmit clock |
| txrst_i | input | 1 | One-cycle transmitter reset strobe |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | 8 | Byte to queue |
| ser_o | output | 1 | Serial data output |
| full_o | output | 1 | FIFO holds 4 bytes |
| empty_o | output | 1 | FIFO holds no byte |
| busy_o | output | 1 | Byte queued or being shifted |

## Verification
A change on tx_clk_i reaches ser_o three system clock edges after it is set: two synchronizer flops, then the output register. The bench therefore changes tx_clk_i on a falling system edge and holds each level for six system cycles. It samples ser_o at the last falling edge of that interval, after the update and before the next transmit-clock change.

Writes and txrst_i strobes take effect at the first rising system edge. Their flags are therefore checked on the falling edge right after it. Each rising-edge check compares ser_o against the expected bit of the byte. Each falling-edge check and each long-pause check compares ser_o against that same bit held.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic {ST_ALIGN, ST_RUN} tx_state_e;
endpackage

// File: rtl/ser_tx_edge.sv
module ser_tx_edge #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[SYNC-1:0], d_i};
  end

  assign rise_o = q[SYNC-1] & ~q[SYNC];
  assign fall_o = ~q[SYNC-1] & q[SYNC];
endmodule

// File: rtl/ser_tx_fifo.sv
module ser_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic do_push, do_pop;

  assign full_o  = (cnt == (AW+1)'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign data_o  = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr_i) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr] <= data_i;
  end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
#(
  parameter int W   = 8,
  localparam int CW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         empty_i,
  input  logic [W-1:0] data_i,
  output logic         pop_o,
  output logic         ser_o,
  output logic         active_o
);
  tx_state_e     st;
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          last;

  assign last  = (cnt == CW'(W-1));
  assign pop_o = (st == ST_RUN) && rise_i && !clr_i && !empty_i && (!active_o || last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_ALIGN;
      sh       <= '0;
      cnt      <= '0;
      active_o <= 1'b0;
      ser_o    <= 1'b1;
    end else if (clr_i) begin
      st       <= ST_ALIGN;
      sh       <= '0;
      cnt      <= '0;
      active_o <= 1'b0;
      ser_o    <= 1'b1;
    end else if (st == ST_ALIGN) begin
      if (fall_i) st <= ST_RUN;
    end else if (rise_i) begin
      if (pop_o) begin
        ser_o    <= data_i[0];
        sh       <= data_i >> 1;
        cnt      <= '0;
        active_o <= 1'b1;
      end else if (active_o && !last) begin
        ser_o <= sh[0];
        sh    <= sh >> 1;
        cnt   <= cnt + 1'b1;
      end else begin
        active_o <= 1'b0;
        ser_o    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_ser_tx.sv
module burst_ser_tx #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int SYNC  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_clk_i,
  input  logic         txrst_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         ser_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         busy_o
);
  logic rise_w, fall_w, pop_w, active_w;
  logic [W-1:0] head_w;

  ser_tx_edge #(.SYNC(SYNC)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tx_clk_i),
    .rise_o(rise_w), .fall_o(fall_w)
  );

  ser_tx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(txrst_i),
    .push_i(wr_i), .data_i(wdata_i), .pop_i(pop_w),
    .data_o(head_w), .full_o(full_o), .empty_o(empty_o)
  );

  ser_tx_shift #(.W(W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(txrst_i),
    .rise_i(rise_w), .fall_i(fall_w), .empty_i(empty_o),
    .data_i(head_w), .pop_o(pop_w), .ser_o(ser_o), .active_o(active_w)
  );

  assign busy_o = active_w | ~empty_o;
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic txrst_i,
  input logic wr_i,
  input logic rise_i,
  input logic ser_o,
  input logic full_o,
  input logic empty_o,
  input logic busy_o
);
  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ser_o);

  // R4
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_o != $past(ser_o)) |-> ($past(rise_i) || $past(txrst_i)));

  // R7
  full_not_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !empty_o);

  // R7
  fill_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(wr_i));

  // R8
  tx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txrst_i |=> (empty_o && ser_o && !busy_o));
endmodule

bind burst_ser_tx ser_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .txrst_i(txrst_i), .wr_i(wr_i),
  .rise_i(rise_w), .ser_o(ser_o), .full_o(full_o), .empty_o(empty_o),
  .busy_o(busy_o)
);

// File: tb/sim_burst_ser_tx.sv
`timescale 1ns/1ps
module sim_burst_ser_tx;
  logic clk = 1'b0, rst_ni = 1'b0, tx_clk = 1'b0, txrst = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic ser, full, empty, busy;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_ser_tx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tx_clk_i(tx_clk), .txrst_i(txrst),
    .wr_i(wr), .wdata_i(wdata), .ser_o(ser), .full_o(full),
    .empty_o(empty), .busy_o(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx_edge(input logic v);
    @(negedge clk) tx_clk = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic host_wr(input logic [7:0] b);
    @(negedge clk) begin wr = 1'b1; wdata = b; end
    @(negedge clk) wr = 1'b0;
  endtask

  task automatic pulse_txrst();
    @(negedge clk) txrst = 1'b1;
    @(negedge clk) txrst = 1'b0;
  endtask

  task automatic send_check(input logic [7:0] b, input string tag);
    for (int i = 0; i < 8; i++) begin
      tx_edge(1'b1);
      chk({tag, " bit on rise"}, ser, b[i]);
      tx_edge(1'b0);
      chk("R4 hold over fall", ser, b[i]);
    end
  endtask

  task automatic t_reset();
    chk("R1 ser idle", ser, 1);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 busy", busy, 0);
  endtask

  task automatic t_stream();
    host_wr(8'h5A);
    chk("R9 busy after write", busy, 1);
    tx_edge(1'b1);
    chk("R2 rise before fall ignored", ser, 1);
    tx_edge(1'b0);
    host_wr(8'h3C);
    send_check(8'h5A, "R3");
    repeat (60) @(negedge clk);
    chk("R4 hold in long gap", ser, 0);
    send_check(8'h3C, "R5");
    tx_edge(1'b1);
    chk("R6 underrun idles high", ser, 1);
    chk("R9 not busy", busy, 0);
    tx_edge(1'b0);
    host_wr(8'h81);
    chk("R6 no launch without rise", ser, 1);
    send_check(8'h81, "R6");
  endtask

  task automatic t_fifo();
    host_wr(8'h11); host_wr(8'h22); host_wr(8'h33);
    chk("R7 not full at 3", full, 0);
    host_wr(8'h44);
    chk("R7 full at 4", full, 1);
    host_wr(8'h55);
    chk("R7 still full", full, 1);
    send_check(8'h11, "R7");
    send_check(8'h22, "R7");
    send_check(8'h33, "R7");
    send_check(8'h44, "R7");
    tx_edge(1'b1);
    chk("R7 dropped write not sent", ser, 1);
    chk("R7 empty at end", empty, 1);
    tx_edge(1'b0);
  endtask

  task automatic t_txrst();
    host_wr(8'h0F); host_wr(8'hF0);
    tx_edge(1'b1);
    chk("R8 first bit before reset", ser, 1);
    tx_edge(1'b0);
    pulse_txrst();
    chk("R8 ser high", ser, 1);
    chk("R8 empty", empty, 1);
    chk("R8 busy", busy, 0);
    host_wr(8'hC2);
    tx_edge(1'b1);
    chk("R2 realign after txrst", ser, 1);
    tx_edge(1'b0);
    send_check(8'hC2, "R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_stream();
    t_fifo();
    t_txrst();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule